// File: doc/BRIEF.md
# Wiper Position Register with Stepping

This block keeps the volatile position of a digitally controlled potentiometer wiper and turns it into a one-hot tap select for the resistor ladder. The position can change in four ways. A serial write loads a byte sent by the host. A transfer copies one of the four default-bank storage registers. A step pulse moves the wiper one tap up or down. An automatic recall copies default register 0 in the first cycle after reset. The same value is also driven out for readback.

Command decoding and nonvolatile storage sit outside the block. The surrounding logic issues single-cycle strobes and supplies the four default-bank register values on a flat bus. Position 0 connects the wiper to the low terminal, and the all-ones position connects it to the high terminal. A load does not reach the tap select at once. It waits a configurable settle count, which models the wiper response time after a load instruction.

Top module: `wiper_pos_reg`

## Requirements
- R1: While reset is asserted, the position reads 0 and tap 0 is selected. In the first clock cycle after reset is released, the position is loaded from default register 0, which is bits [7:0] of `bankData`.
- R2: Exactly one bit of `tapSelect` is set in every cycle.
- R3: Bit n of `tapSelect` is set when the displayed position is n. Position 0x00 therefore selects bit 0 (the low terminal), and 0xFF selects bit 255 (the high terminal).
- R4: When a step pulse has `stepDir`=1, the position rises by one at the next clock edge. When a step pulse has `stepDir`=0, the position falls by one at the next clock edge.
- R5: Stepping up from 0xFF leaves the position at 0xFF. Stepping down from 0x00 leaves it at 0x00. Neither direction wraps around.
- R6: A transfer loads the register whose index is `xferIdx`. Register k occupies bits [8k+7:8k] of `bankData`, and only these four default-bank registers are reachable.
- R7: If a load (recall, serial write or transfer) and a step pulse arrive in the same cycle, the load decides the new position and the step is dropped.
- R8: Loads that coincide are ranked in a fixed order. Recall comes first, then the serial write, then the transfer.
- R9: The tap select lags the position by one edge. After any load it is frozen for `SETTLE_CYCLES` further edges, so a load taken at edge k first shows on `tapSelect` after edge k+SETTLE_CYCLES+1. A new load during the freeze restarts it.
- R10: A serial-load strobe stores `serialData` into the position at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| serialLoad | input | 1 | Strobe: load `serialData` |
| serialData | input | 8 | Byte for a serial write |
| xferLoad | input | 1 | Strobe: load the default-bank register chosen by `xferIdx` |
| xferIdx | input | 2 | Default-bank register index for a transfer |
| bankData | input | 32 | The four default-bank register values, register k at bits [8k+7:8k] |
| stepPulse | input | 1 | Strobe: move the position one tap |
| stepDir | input | 1 | Step direction: 1 toward the high terminal, 0 toward the low terminal |
| wiperValue | output | 8 | Current position, for readback |
| tapSelect | output | 256 | One-hot tap enable |

## Verification
Several functions can fall in the same cycle. A step pulse can coincide with a serial write or a transfer, a serial write can coincide with a transfer, and the bench also raises a serial write during the recall cycle right after reset. Directed cycles raise each of these pairs together. Constrained random traffic then sets the strobes independently, so such collisions occur many times. In each case the bench judges the position and the tap select against a model built from the ranking and settle rules, one cycle at a time.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  // Per-cycle action chosen by the control, applied by the datapath.
  typedef struct packed {
    logic ldRecall;
    logic ldSerial;
    logic ldXfer;
    logic stepUp;
    logic stepDn;
  } wiperStrb_t;
endpackage

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
  import wiper_pkg::*;
#(
  parameter int SETTLE_CYCLES = 6,
  localparam int CNT_W = (SETTLE_CYCLES < 1) ? 1 : $clog2(SETTLE_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serialLoad,
  input  logic       xferLoad,
  input  logic       stepPulse,
  input  logic       stepDir,
  output wiperStrb_t strb,
  output logic       recallBusy,
  output logic       tapUpdate
);
  logic [CNT_W-1:0] settleCnt;
  logic             anyLoad;

  // Fixed ranking: recall, then serial write, then transfer, then step.
  always_comb begin
    strb          = '0;
    strb.ldRecall = recallBusy;
    strb.ldSerial = !recallBusy && serialLoad;
    strb.ldXfer   = !recallBusy && !serialLoad && xferLoad;
    anyLoad       = strb.ldRecall || strb.ldSerial || strb.ldXfer;
    strb.stepUp   = !anyLoad && stepPulse && stepDir;
    strb.stepDn   = !anyLoad && stepPulse && !stepDir;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      recallBusy <= 1'b1;
      settleCnt  <= '0;
    end else begin
      recallBusy <= 1'b0;
      if (anyLoad)
        settleCnt <= CNT_W'(SETTLE_CYCLES);
      else if (settleCnt != '0)
        settleCnt <= settleCnt - 1'b1;
    end
  end

  assign tapUpdate = (settleCnt == '0) && !recallBusy;
endmodule

// File: rtl/wiper_dp.sv
module wiper_dp
  import wiper_pkg::*;
#(
  parameter int POS_W     = 8,
  parameter int BANK_REGS = 4,
  localparam int IDX_W    = $clog2(BANK_REGS),
  localparam int TAPS     = 1 << POS_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  wiperStrb_t                 strb,
  input  logic                       tapUpdate,
  input  logic [POS_W-1:0]           serialData,
  input  logic [IDX_W-1:0]           xferIdx,
  input  logic [BANK_REGS*POS_W-1:0] bankData,
  output logic [POS_W-1:0]           wiperValue,
  output logic [TAPS-1:0]            tapSelect
);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  logic [POS_W-1:0] bankReg [BANK_REGS];
  logic [POS_W-1:0] wiperNext;
  logic [POS_W-1:0] tapPos;

  for (genvar g = 0; g < BANK_REGS; g++) begin : gBank
    assign bankReg[g] = bankData[g*POS_W +: POS_W];
  end

  always_comb begin
    wiperNext = wiperValue;
    if (strb.ldRecall)
      wiperNext = bankReg[0];
    else if (strb.ldSerial)
      wiperNext = serialData;
    else if (strb.ldXfer)
      wiperNext = bankReg[xferIdx];
    else if (strb.stepUp && wiperValue != POS_MAX)
      wiperNext = wiperValue + 1'b1;
    else if (strb.stepDn && wiperValue != '0)
      wiperNext = wiperValue - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wiperValue <= '0;
      tapPos     <= '0;
    end else begin
      wiperValue <= wiperNext;
      if (tapUpdate)
        tapPos <= wiperValue;
    end
  end

  for (genvar t = 0; t < TAPS; t++) begin : gTap
    assign tapSelect[t] = (tapPos == POS_W'(t));
  end
endmodule

// File: rtl/wiper_pos_reg.sv
module wiper_pos_reg
  import wiper_pkg::*;
#(
  parameter int POS_W         = 8,
  parameter int BANK_REGS     = 4,
  parameter int SETTLE_CYCLES = 6,
  localparam int IDX_W        = $clog2(BANK_REGS),
  localparam int TAPS         = 1 << POS_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       serialLoad,
  input  logic [POS_W-1:0]           serialData,
  input  logic                       xferLoad,
  input  logic [IDX_W-1:0]           xferIdx,
  input  logic [BANK_REGS*POS_W-1:0] bankData,
  input  logic                       stepPulse,
  input  logic                       stepDir,
  output logic [POS_W-1:0]           wiperValue,
  output logic [TAPS-1:0]            tapSelect
);
  wiperStrb_t strb;
  logic       recallBusy;
  logic       tapUpdate;

  wiper_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .serialLoad(serialLoad), .xferLoad(xferLoad),
    .stepPulse(stepPulse), .stepDir(stepDir), .strb(strb),
    .recallBusy(recallBusy), .tapUpdate(tapUpdate)
  );

  wiper_dp #(.POS_W(POS_W), .BANK_REGS(BANK_REGS)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .tapUpdate(tapUpdate),
    .serialData(serialData), .xferIdx(xferIdx), .bankData(bankData),
    .wiperValue(wiperValue), .tapSelect(tapSelect)
  );
endmodule

// File: rtl/wiper_pos_chk.sv
module wiper_pos_chk
  import wiper_pkg::*;
#(
  parameter int POS_W     = 8,
  parameter int BANK_REGS = 4,
  localparam int IDX_W    = $clog2(BANK_REGS),
  localparam int TAPS     = 1 << POS_W
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       serialLoad,
  input logic [POS_W-1:0]           serialData,
  input logic                       xferLoad,
  input logic [IDX_W-1:0]           xferIdx,
  input logic [BANK_REGS*POS_W-1:0] bankData,
  input logic                       stepPulse,
  input logic [POS_W-1:0]           wiperValue,
  input logic [TAPS-1:0]            tapSelect,
  input wiperStrb_t                 strb,
  input logic                       recallBusy,
  input logic                       tapUpdate
);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  logic [POS_W-1:0] bankReg [BANK_REGS];
  for (genvar g = 0; g < BANK_REGS; g++) begin : gBank
    assign bankReg[g] = bankData[g*POS_W +: POS_W];
  end
  logic [POS_W-1:0] xferSel;
  assign xferSel = bankReg[xferIdx];

  assert_recall_R1: assert property (@(posedge clk) disable iff (!rstN)
    recallBusy |=> (wiperValue == $past(bankData[POS_W-1:0])) && !recallBusy);

  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $countones(tapSelect) == 1);

  assert_step_up_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepUp && wiperValue != POS_MAX) |=> wiperValue == POS_W'($past(wiperValue) + 1'b1));

  assert_step_dn_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepDn && wiperValue != '0) |=> wiperValue == POS_W'($past(wiperValue) - 1'b1));

  assert_sat_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepUp && wiperValue == POS_MAX) |=> wiperValue == POS_MAX);

  assert_sat_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepDn && wiperValue == '0) |=> wiperValue == '0);

  assert_xfer_R6: assert property (@(posedge clk) disable iff (!rstN)
    (xferLoad && !serialLoad && !recallBusy) |=> wiperValue == $past(xferSel));

  assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    (serialLoad && stepPulse && !recallBusy) |=> wiperValue == $past(serialData));

  assert_serial_R10: assert property (@(posedge clk) disable iff (!rstN)
    (serialLoad && !recallBusy) |=> wiperValue == $past(serialData));

  assert_freeze_R9: assert property (@(posedge clk) disable iff (!rstN)
    !tapUpdate |=> $stable(tapSelect));

  assert_follow_R9: assert property (@(posedge clk) disable iff (!rstN)
    tapUpdate |=> tapSelect[$past(wiperValue)]);
endmodule

bind wiper_pos_reg wiper_pos_chk #(.POS_W(POS_W), .BANK_REGS(BANK_REGS)) uChk (
  .clk(clk), .rstN(rstN), .serialLoad(serialLoad), .serialData(serialData),
  .xferLoad(xferLoad), .xferIdx(xferIdx), .bankData(bankData),
  .stepPulse(stepPulse), .wiperValue(wiperValue), .tapSelect(tapSelect),
  .strb(strb), .recallBusy(recallBusy), .tapUpdate(tapUpdate)
);

// File: tb/sim_wiper_pos_reg.sv
module sim_wiper_pos_reg;
  localparam int SETTLE = 6;

  logic         clk = 1'b0;
  logic         rstN;
  logic         serialLoad;
  logic [7:0]   serialData;
  logic         xferLoad;
  logic [1:0]   xferIdx;
  logic [31:0]  bankData;
  logic         stepPulse;
  logic         stepDir;
  logic [7:0]   wiperValue;
  logic [255:0] tapSelect;

  int total = 0;
  int bad   = 0;

  // Reference state derived from the requirements.
  logic [7:0] mW, mTap;
  int         mCnt;
  logic       mRec;

  always #4 clk = ~clk;

  wiper_pos_reg #(.SETTLE_CYCLES(SETTLE)) u0 (
    .clk(clk), .rstN(rstN), .serialLoad(serialLoad), .serialData(serialData),
    .xferLoad(xferLoad), .xferIdx(xferIdx), .bankData(bankData),
    .stepPulse(stepPulse), .stepDir(stepDir),
    .wiperValue(wiperValue), .tapSelect(tapSelect)
  );

  function automatic logic [255:0] oneHot(input logic [7:0] p);
    logic [255:0] v = '0;
    v[p] = 1'b1;
    return v;
  endfunction

  function automatic logic [7:0] bankAt(input logic [31:0] b, input logic [1:0] k);
    return b[k*8 +: 8];
  endfunction

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkTap(input string tag);
    total++;
    if (tapSelect !== oneHot(mTap)) begin
      bad++;
      $display("FAIL %s tap: actual=%h expected=%h", tag, tapSelect, oneHot(mTap));
    end
  endtask

  task automatic idleIn();
    serialLoad = 0; xferLoad = 0; stepPulse = 0;
  endtask

  // One clock: advance the model at the edge, compare at the falling edge.
  task automatic tick(input string tag);
    logic [7:0] oW;
    int oC;
    logic oR, ld;
    @(posedge clk);
    oW = mW; oC = mCnt; oR = mRec;
    if (oC == 0 && !oR) mTap = oW;
    ld = oR || serialLoad || xferLoad;
    if (oR) mW = bankAt(bankData, 2'd0);
    else if (serialLoad) mW = serialData;
    else if (xferLoad) mW = bankAt(bankData, xferIdx);
    else if (stepPulse && stepDir && oW != 8'hFF) mW = oW + 8'd1;
    else if (stepPulse && !stepDir && oW != 8'h00) mW = oW - 8'd1;
    mRec = 1'b0;
    if (ld) mCnt = SETTLE;
    else if (oC > 0) mCnt = oC - 1;
    @(negedge clk);
    check8(tag, wiperValue, mW);
    checkTap({tag, " R2 R9"});
  endtask

  task automatic settle(input string tag);
    idleIn();
    for (int i = 0; i < SETTLE + 2; i++) tick(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 0; idleIn(); serialData = 0; xferIdx = 0; stepDir = 0;
    bankData = 32'hC3_81_42_9D;
    mW = 0; mTap = 0; mCnt = 0; mRec = 1;
    repeat (3) @(negedge clk);
    check8("R1 reset value", wiperValue, 8'h00);
    checkTap("R1 reset");
    // R8: serial write during the recall cycle loses to the recall.
    rstN = 1; serialLoad = 1; serialData = 8'h33;
    tick("R1 R8 recall");
    check8("R1 recalled reg0", wiperValue, 8'h9D);
    settle("R9 after recall");

    serialLoad = 1; serialData = 8'h5A; tick("R10 serial write");
    settle("R9 settle");

    serialLoad = 1; serialData = 8'hFF; tick("R10 load FF");
    settle("R9");
    stepDir = 1; stepPulse = 1;
    for (int i = 0; i < 3; i++) tick("R5 saturate high");
    idleIn(); tick("R3");
    total++;
    if (tapSelect[255] !== 1'b1) begin
      bad++; $display("FAIL R3 high end: actual=%b expected=1", tapSelect[255]);
    end

    serialLoad = 1; serialData = 8'h01; tick("R10 load 01");
    settle("R9");
    stepDir = 0; stepPulse = 1;
    for (int i = 0; i < 3; i++) tick("R5 saturate low");
    idleIn(); tick("R3");
    total++;
    if (tapSelect[0] !== 1'b1) begin
      bad++; $display("FAIL R3 low end: actual=%b expected=1", tapSelect[0]);
    end
    stepDir = 1; stepPulse = 1;
    for (int i = 0; i < 4; i++) tick("R4 step up");
    stepDir = 0;
    tick("R4 step down");

    idleIn(); xferLoad = 1; xferIdx = 2'd2; tick("R6 transfer idx2");
    xferIdx = 2'd3; stepPulse = 1; stepDir = 1; tick("R7 transfer beats step");
    xferLoad = 0; serialLoad = 1; serialData = 8'h10; stepDir = 0; tick("R7 serial beats step");
    stepPulse = 0; xferLoad = 1; xferIdx = 2'd1; serialData = 8'hEE; tick("R8 serial beats transfer");
    settle("R9");

    for (int n = 0; n < 3000; n++) begin
      serialLoad = ($urandom_range(0, 9) == 0);
      serialData = 8'($urandom);
      xferLoad   = ($urandom_range(0, 9) == 0);
      xferIdx    = 2'($urandom);
      stepPulse  = ($urandom_range(0, 1) == 0);
      stepDir    = ($urandom_range(0, 99) < 50);
      if ($urandom_range(0, 31) == 0) bankData = $urandom;
      if ($urandom_range(0, 199) == 0) serialData = ($urandom_range(0, 1) == 0) ? 8'h00 : 8'hFF;
      tick("RND R4 R5 R6 R7 R8 R9 R10");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule